// File: doc/BRIEF.md
# Clock Source Enable and System Clock Switch Controller

This block is the control core of a clock management unit. It keeps one enable bit and one ready flag for four sources: an internal oscillator, an external oscillator, a main PLL and a secondary PLL. It also selects which of the first three sources drives the system clock. Source start-up and PLL lock are modelled by per-source timers. Each timer raises the source's ready flag a fixed number of cycles after the source is enabled.

Software reaches three word registers through a plain single-cycle read/write bus. Reads are combinational from the address. The control word holds the enables, the ready flags and two plain option bits. The switch word holds a 2-bit source request and a 2-bit source status. The third word is a 32-bit PLL configuration word that the unit stores and does not interpret.

The status moves to the requested source only once that source reports ready. While it waits, the request stays pending. The enable of the source driving the system clock cannot be cleared. The same holds for a source that is being selected in that cycle, so the system clock always has a running source.

Top module: `ccu_top`

## Requirements
- R1: After reset, the control word (address 0) reads 0x00000003, meaning the internal oscillator is enabled and ready. The switch word (address 1) reads 0, the PLL word (address 2) reads 0x24003010, and `sys_sel_o` is 0.
- R2: Control word enable bits are: internal oscillator at bit 0, external oscillator at bit 16, main PLL at bit 24 and secondary PLL at bit 28. The ready flags are at bits 1, 17, 25 and 29. A source's ready flag rises exactly DLY clock edges after the edge that writes its enable to 1. DLY is 2, 6, 10 and 8 for the four sources by default.
- R3: Writing a source's enable to 0 clears its ready flag at the next edge. Enabling it again restarts the full DLY wait.
- R4: Ready flags are read-only. Bus writes to bits 1, 17, 25 and 29 have no effect.
- R5: The switch word holds the request in bits 1:0 and the status in bits 3:2. Both use the codes 0 for internal, 1 for external and 2 for PLL, and `sys_sel_o` mirrors the status. When the requested source is ready and differs from the status, the status takes the request at the next edge.
- R6: A request for a source that is not ready stays pending. The status keeps the previous source until the requested source becomes ready.
- R7: A write that clears the enable of the source shown in the status is ignored for that bit. The same applies to the source the status takes at that same edge.
- R8: Writing request code 3 to the switch word leaves the request unchanged. Bits 31:4 of the switch word read 0.
- R9: Control bits 18 and 19 are plain read/write bits. All 32 bits of the PLL word are read/write.
- R10: Addresses other than 0, 1 and 2 read 0. Writes to them change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bus_we_i | input | 1 | Write strobe for the addressed word |
| bus_addr_i | input | 3 | Word address |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data of the addressed word, combinational |
| sys_sel_o | output | 2 | Source currently driving the system clock |

## Verification
The bench checks the exact edge at which each ready flag rises. A timer that counted one edge too many or too few would flip the compared control word a cycle off. The bench requests a source that is not ready and holds the request. A design that switched regardless would show the new status at once. It also clears enables while a switch is completing in the same cycle. A design that protected only the old status would disable the source it had just selected. It then re-enables the secondary PLL to confirm that the wait starts over, and writes set ready bits to show they cannot be forced.

// File: rtl/ccu_pkg.sv
package ccu_pkg;

  typedef enum logic [1:0] {
    SRC_INT = 2'd0,
    SRC_EXT = 2'd1,
    SRC_PLL = 2'd2,
    SRC_RSV = 2'd3
  } src_e;

  // source index: 0 internal, 1 external, 2 main pll, 3 secondary pll
  localparam int unsigned NSRC  = 4;
  localparam int unsigned NSYS  = 3;
  localparam int unsigned REG_W = 32;

  localparam int unsigned EN_POS  [NSRC] = '{0, 16, 24, 28};
  localparam int unsigned RDY_POS [NSRC] = '{1, 17, 25, 29};
  localparam int unsigned BYP_POS = 18;
  localparam int unsigned CSS_POS = 19;

  localparam logic [REG_W-1:0] PLLCFG_RST = 32'h2400_3010;

  localparam int unsigned A_CTRL = 0;
  localparam int unsigned A_CFG  = 1;
  localparam int unsigned A_PLL  = 2;

endpackage

// File: rtl/ccu_rdy_timer.sv
module ccu_rdy_timer #(
  parameter int unsigned DLY     = 4,
  parameter bit          RST_RDY = 1'b0
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  output logic rdy_o
);

  localparam int unsigned CW = (DLY > 1) ? $clog2(DLY) : 1;

  logic [CW-1:0] cnt_q;
  logic          rdy_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      rdy_q <= RST_RDY;
    end else if (!en_i) begin
      cnt_q <= '0;
      rdy_q <= 1'b0;
    end else if (!rdy_q) begin
      if (cnt_q == CW'(DLY - 1)) rdy_q <= 1'b1;
      else                       cnt_q <= cnt_q + 1'b1;
    end
  end

  assign rdy_o = rdy_q;

  assert_rdy_drop_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> !rdy_o);

  assert_rdy_needs_en_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rdy_o) |-> $past(en_i));

endmodule

// File: rtl/ccu_switch.sv
module ccu_switch
  import ccu_pkg::*;
(
  input  logic            clk_i,
  input  logic            rst_ni,
  input  src_e            req_i,
  input  logic [NSRC-1:0] rdy_i,
  output src_e            stat_o,
  output src_e            stat_nxt_o
);

  src_e stat_q;
  logic req_rdy;

  always_comb begin
    unique case (req_i)
      SRC_INT: req_rdy = rdy_i[0];
      SRC_EXT: req_rdy = rdy_i[1];
      SRC_PLL: req_rdy = rdy_i[2];
      default: req_rdy = 1'b0;
    endcase
  end

  assign stat_nxt_o = req_rdy ? req_i : stat_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) stat_q <= SRC_INT;
    else         stat_q <= stat_nxt_o;
  end

  assign stat_o = stat_q;

  assert_stat_to_ready_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stat_q != $past(stat_q)) |-> $past(rdy_i[stat_q]));

  assert_stat_pending_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_rdy |=> $stable(stat_q));

  assert_stat_legal_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stat_q != SRC_RSV);

endmodule

// File: rtl/ccu_top.sv
module ccu_top
  import ccu_pkg::*;
#(
  parameter int unsigned ADDR_W   = 3,
  parameter int unsigned INT_DLY  = 2,
  parameter int unsigned EXT_DLY  = 6,
  parameter int unsigned PLL_DLY  = 10,
  parameter int unsigned SPLL_DLY = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              bus_we_i,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic [REG_W-1:0]  bus_wdata_i,
  output logic [REG_W-1:0]  bus_rdata_o,
  output logic [1:0]        sys_sel_o
);

  localparam int unsigned    DLY_TAB [NSRC] = '{INT_DLY, EXT_DLY, PLL_DLY, SPLL_DLY};
  localparam logic [NSRC-1:0] EN_RST = NSRC'(1);

  logic [NSRC-1:0] en_q, en_wr, rdy, keep;
  logic            byp_q, css_q;
  logic [REG_W-1:0] pll_q;
  src_e            req_q, stat, stat_nxt;
  logic            wr_ctrl, wr_cfg, wr_pll;

  assign wr_ctrl = bus_we_i && (bus_addr_i == ADDR_W'(A_CTRL));
  assign wr_cfg  = bus_we_i && (bus_addr_i == ADDR_W'(A_CFG));
  assign wr_pll  = bus_we_i && (bus_addr_i == ADDR_W'(A_PLL));

  // hold the enable of the running source and of the one being switched in
  always_comb begin
    keep           = '0;
    keep[stat]     = 1'b1;
    keep[stat_nxt] = 1'b1;
  end

  for (genvar i = 0; i < NSRC; i++) begin : g_src
    if (i < NSYS) begin : g_sys
      assign en_wr[i] = bus_wdata_i[EN_POS[i]] | keep[i];
    end else begin : g_aux
      assign en_wr[i] = bus_wdata_i[EN_POS[i]];
    end

    ccu_rdy_timer #(
      .DLY     (DLY_TAB[i]),
      .RST_RDY (i == 0)
    ) u_timer (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .en_i   (en_q[i]),
      .rdy_o  (rdy[i])
    );
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q  <= EN_RST;
      byp_q <= 1'b0;
      css_q <= 1'b0;
    end else if (wr_ctrl) begin
      en_q  <= en_wr;
      byp_q <= bus_wdata_i[BYP_POS];
      css_q <= bus_wdata_i[CSS_POS];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                                       req_q <= SRC_INT;
    else if (wr_cfg && (bus_wdata_i[1:0] != SRC_RSV)) req_q <= src_e'(bus_wdata_i[1:0]);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     pll_q <= PLLCFG_RST;
    else if (wr_pll) pll_q <= bus_wdata_i;
  end

  ccu_switch u_switch (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .req_i      (req_q),
    .rdy_i      (rdy & NSRC'(7)),
    .stat_o     (stat),
    .stat_nxt_o (stat_nxt)
  );

  always_comb begin
    bus_rdata_o = '0;
    if (bus_addr_i == ADDR_W'(A_CTRL)) begin
      for (int i = 0; i < NSRC; i++) begin
        bus_rdata_o[EN_POS[i]]  = en_q[i];
        bus_rdata_o[RDY_POS[i]] = rdy[i];
      end
      bus_rdata_o[BYP_POS] = byp_q;
      bus_rdata_o[CSS_POS] = css_q;
    end else if (bus_addr_i == ADDR_W'(A_CFG)) begin
      bus_rdata_o[1:0] = req_q;
      bus_rdata_o[3:2] = stat;
    end else if (bus_addr_i == ADDR_W'(A_PLL)) begin
      bus_rdata_o = pll_q;
    end
  end

  assign sys_sel_o = stat;

  assert_sel_enabled_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_q[stat]);

  assert_rdy_readonly_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_ctrl && !en_q[1] && bus_wdata_i[RDY_POS[1]]) |=> !rdy[1]);

  assert_req_no_rsv_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_q != SRC_RSV);

endmodule

// File: tb/ccu_top_bench.sv
`timescale 1ns/1ps
module ccu_top_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        we = 1'b0;
  logic [2:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [1:0]  sel;

  int n_cmp = 0;
  int n_bad = 0;
  string phase = "R1";

  always #2.5 clk = ~clk;

  ccu_top u_ccu_top (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .bus_we_i    (we),
    .bus_addr_i  (addr),
    .bus_wdata_i (wdata),
    .bus_rdata_o (rdata),
    .sys_sel_o   (sel)
  );

  // behavioural reference
  localparam int DLY [4] = '{2, 6, 10, 8};
  localparam int ENB [4] = '{0, 16, 24, 28};
  localparam int RDB [4] = '{1, 17, 25, 29};
  int m_en[4], m_rdy[4], m_age[4];
  int m_req, m_stat, m_byp, m_css;
  logic [31:0] m_pll;

  always @(posedge clk or negedge rst_n) begin
    int nstat, nen[4];
    if (!rst_n) begin
      for (int i = 0; i < 4; i++) begin
        m_en[i] = (i == 0); m_rdy[i] = (i == 0); m_age[i] = 0;
      end
      m_req = 0; m_stat = 0; m_byp = 0; m_css = 0; m_pll = 32'h2400_3010;
    end else begin
      nstat = m_stat;
      if (m_rdy[m_req] != 0) nstat = m_req;
      for (int i = 0; i < 4; i++) nen[i] = m_en[i];
      if (we && addr == 0) begin
        for (int i = 0; i < 4; i++) begin
          nen[i] = wdata[ENB[i]];
          if (i < 3 && (i == m_stat || i == nstat)) nen[i] = 1;
        end
        m_byp = wdata[18]; m_css = wdata[19];
      end
      if (we && addr == 1 && wdata[1:0] != 2'd3) m_req = wdata[1:0];
      if (we && addr == 2) m_pll = wdata;
      // ready: DLY edges of continuous enable
      for (int i = 0; i < 4; i++) begin
        if (m_en[i] == 0) begin m_rdy[i] = 0; m_age[i] = 0; end
        else if (m_rdy[i] == 0) begin
          m_age[i]++;
          if (m_age[i] >= DLY[i]) m_rdy[i] = 1;
        end
      end
      for (int i = 0; i < 4; i++) m_en[i] = nen[i];
      m_stat = nstat;
    end
  end

  function automatic logic [31:0] m_read(input logic [2:0] a);
    logic [31:0] v = '0;
    if (a == 0) begin
      for (int i = 0; i < 4; i++) begin
        v[ENB[i]] = m_en[i][0];
        v[RDB[i]] = m_rdy[i][0];
      end
      v[18] = m_byp[0]; v[19] = m_css[0];
    end else if (a == 1) begin
      v[1:0] = m_req[1:0]; v[3:2] = m_stat[1:0];
    end else if (a == 2) v = m_pll;
    return v;
  endfunction

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string what);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", phase, what, act, exp);
    end
  endtask

  // compare at negedge, then drive next bus cycle
  task automatic step(input logic w, input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    chk(rdata, m_read(addr), $sformatf("rdata@%0d", addr));
    chk({30'd0, sel}, m_stat, "sys_sel");
    we = w; addr = a; wdata = d;
  endtask

  task automatic idle(input logic [2:0] a, input int n);
    for (int k = 0; k < n; k++) step(1'b0, a, '0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1: explicit reset values
    chk(rdata, 32'h0000_0003, "reset ctrl");
    addr = 3'd1; #0.1;
    chk(rdata, 32'h0, "reset cfg");
    chk({30'd0, sel}, 0, "reset sel");
    addr = 3'd2; #0.1;
    chk(rdata, 32'h2400_3010, "reset pll");
    addr = 3'd0;
    @(negedge clk); rst_n = 1'b1;
    idle(0, 2); idle(1, 1); idle(2, 1);

    phase = "R6"; // PLL requested while off stays pending
    step(1'b1, 1, 32'h2);
    idle(1, 15);

    phase = "R2"; // enable ext and pll, watch ready timing
    step(1'b1, 0, 32'h0101_0001);
    idle(0, 12);
    phase = "R5";
    idle(1, 4);

    phase = "R7"; // clear all: pll (selected) held, others drop
    step(1'b1, 0, 32'h0);
    idle(0, 6); idle(1, 2);

    phase = "R5"; // request int while off, then enable it
    step(1'b1, 1, 32'h0);
    idle(1, 4);
    step(1'b1, 0, 32'h0100_0001);
    idle(0, 4); idle(1, 3);
    step(1'b1, 1, 32'h1);         // ext off: pending
    idle(1, 3);
    step(1'b1, 0, 32'h0101_0001);
    idle(0, 8); idle(1, 3);

    phase = "R7"; // request int then clear enables while switch completes
    step(1'b1, 1, 32'h0);
    step(1'b1, 0, 32'h0);
    idle(0, 12); idle(1, 2);

    phase = "R3"; // secondary pll drop and re-lock
    step(1'b1, 0, 32'h1000_0001);
    idle(0, 10);
    step(1'b1, 0, 32'h0000_0001);
    idle(0, 3);
    step(1'b1, 0, 32'h1000_0001);
    idle(0, 10);

    phase = "R4"; // ready bits written high with enables low
    step(1'b1, 0, 32'h2202_0003);
    idle(0, 12);

    phase = "R8";
    step(1'b1, 1, 32'h3);
    idle(1, 3);
    step(1'b1, 1, 32'hFFFF_FFF2);
    idle(1, 3);

    phase = "R9";
    step(1'b1, 2, 32'hA5A5_5A5A);
    idle(2, 2);
    step(1'b1, 0, 32'h000C_0001);
    idle(0, 2);
    step(1'b1, 0, 32'h0004_0001);
    idle(0, 2);

    phase = "R10";
    step(1'b1, 3, 32'hFFFF_FFFF);
    idle(3, 2);
    step(1'b1, 7, 32'hFFFF_FFFF);
    idle(7, 2); idle(0, 1); idle(1, 1); idle(2, 1);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule